// File: doc/BRIEF.md
# Region-Attributed Write-Policy Data Cache Controller

This block sits between a processor load/store port and a burst memory port. It is a small direct-mapped data cache. It does not use one global write policy. Each access takes its policy from the top three address bits. Code-like and low-RAM regions are write-through. Two SRAM-like regions are write-back with write-allocate. All remaining space is treated as device or strongly-ordered memory, which is never cached and goes straight to memory.

Write-back lines are marked dirty and reach memory only when they are evicted. A dirty victim is first copied into a one-line write buffer. The buffer drains on the write channel while the refill proceeds on the read channel. A refill of the line that is still held in the buffer is delayed until the buffer has drained, so a read never returns stale memory contents.

Back-pressure follows valid/ready on every channel. The CPU holds `cpu_valid` and its request fields until `cpu_ready` is high at a clock edge. For a load, `cpu_rdata` is valid in that same cycle. The controller keeps each memory `*_valid` and its payload stable until the matching `*_ready`. It raises `mem_r_ready` only while it expects read beats.

Top module: `cc_policy_cache`

## Requirements
- R1: After reset, `cpu_ready`, `mem_ar_valid`, `mem_aw_valid` and `mem_w_valid` are low and every line is invalid, so the first cacheable access misses.
- R2: Region is decoded from `cpu_addr[31:29]`: values 0 and 4 are write-through, values 1 and 3 are write-back write-allocate, and values 2, 5, 6 and 7 are uncached device space.
- R3: A load that hits completes in the cycle it is presented (`cpu_ready` high with no wait) with the stored word, and it issues no memory traffic.
- R4: A cacheable load miss issues one read burst at the line-aligned address with `mem_ar_len` = 7 (eight 32-bit beats, ascending word order), fills the 32-byte line, and returns the requested word.
- R5: A store that hits a write-through line updates the cached bytes selected by `cpu_be`. It also issues one write with `mem_aw_len` = 0 to the same address, carrying the same data and `cpu_be` as `mem_w_strb`.
- R6: A store that misses in a write-through region allocates nothing and only forwards a single-beat write, so a later load of that address misses and refills.
- R7: A store to a write-back region writes only the cache and marks the line dirty, with no write-channel traffic. On a miss it first refills the line and then merges the store.
- R8: When a miss replaces a dirty line, the victim's eight words are written out as one burst (`mem_aw_len` = 7, victim line address, `mem_w_last` on the eighth beat). A clean victim causes no write.
- R9: Device loads and stores each use a single-beat transfer (length 0) and are never allocated, so repeating a device load goes to memory again.
- R10: A refill of the line currently held in the write buffer is not issued until the buffer has drained, so the load returns the data the evicted line carried.
- R11: `cpu_ready` is only high while `cpu_valid` is high, and a memory write request held without `mem_aw_ready` stays valid until accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | CPU request valid |
| cpu_ready | output | 1 | Request completes at this edge |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_be | input | 4 | Store byte enables |
| cpu_rdata | output | 32 | Load data, valid with cpu_ready |
| mem_ar_valid | output | 1 | Read request valid |
| mem_ar_ready | input | 1 | Read request accepted |
| mem_ar_addr | output | 32 | Read start address |
| mem_ar_len | output | 3 | Read beats minus one |
| mem_r_valid | input | 1 | Read beat valid |
| mem_r_ready | output | 1 | Controller accepts read beat |
| mem_r_data | input | 32 | Read beat data |
| mem_aw_valid | output | 1 | Write request valid |
| mem_aw_ready | input | 1 | Write request accepted |
| mem_aw_addr | output | 32 | Write start address |
| mem_aw_len | output | 3 | Write beats minus one |
| mem_w_valid | output | 1 | Write beat valid |
| mem_w_ready | input | 1 | Write beat accepted |
| mem_w_data | output | 32 | Write beat data |
| mem_w_strb | output | 4 | Write beat byte strobes |
| mem_w_last | output | 1 | Final beat of a write burst |

## Verification
The bench sweeps all eight region codes and checks burst length and write-channel traffic for each. A wrong decode would show up as a missing or extra write, or a read burst of the wrong length. It replaces a dirty write-back line with a line from another region at the same index and checks the evicted data in the memory model. A design that dropped the dirty bit would lose the store, and one that evicted clean lines would emit extra bursts. It also makes memory accept write beats slowly and reads the just-evicted line back at once. A controller that refills before the drain completes returns the stale background pattern instead of the stored word.

// File: rtl/cc_pkg.sv
package cc_pkg;
  typedef enum logic [1:0] {
    RG_WT  = 2'd0,
    RG_WB  = 2'd1,
    RG_DEV = 2'd2
  } region_e;

  typedef enum logic [2:0] {
    S_LOOK,
    S_EVICT,
    S_FILL_REQ,
    S_FILL,
    S_WR_REQ,
    S_WR_DATA,
    S_UNC_REQ,
    S_UNC_DATA
  } ctl_state_e;
endpackage

// File: rtl/cc_region_map.sv
module cc_region_map
  import cc_pkg::*;
(
  input  logic [2:0] top_bits,
  output region_e    region
);
  always_comb begin
    case (top_bits)
      3'd0, 3'd4: region = RG_WT;
      3'd1, 3'd3: region = RG_WB;
      default:    region = RG_DEV;
    endcase
  end
endmodule

// File: rtl/cc_tag_store.sv
module cc_tag_store #(
  parameter int NUM_LINES = 8,
  parameter int TAG_W     = 24,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  output logic             rd_valid,
  output logic             rd_dirty,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             wr_en,
  input  logic             wr_valid,
  input  logic             wr_dirty,
  input  logic [TAG_W-1:0] wr_tag
);
  logic [NUM_LINES-1:0] valid_q;
  logic [NUM_LINES-1:0] dirty_q;
  logic [TAG_W-1:0]     tag_q [NUM_LINES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (wr_en) begin
      valid_q[idx] <= wr_valid;
      dirty_q[idx] <= wr_dirty;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[idx] <= wr_tag;
  end

  assign rd_valid = valid_q[idx];
  assign rd_dirty = dirty_q[idx];
  assign rd_tag   = tag_q[idx];

  AST_DIRTY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && wr_dirty) |-> wr_valid); // R7
endmodule

// File: rtl/cc_write_buffer.sv
module cc_write_buffer #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int WORDS   = 8,
  localparam int OFF_W  = $clog2(WORDS * DATA_W / 8),
  localparam int LINE_W = ADDR_W - OFF_W,
  localparam int WSEL_W = $clog2(WORDS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [LINE_W-1:0]       load_line,
  input  logic [WORDS*DATA_W-1:0] load_data,
  output logic                    busy,
  output logic [LINE_W-1:0]       line_addr,
  output logic                    aw_valid,
  input  logic                    aw_ready,
  output logic [ADDR_W-1:0]       aw_addr,
  output logic                    w_valid,
  input  logic                    w_ready,
  output logic [DATA_W-1:0]       w_data,
  output logic                    w_last
);
  typedef enum logic [1:0] {WB_IDLE, WB_ADDR, WB_DATA} wb_state_e;

  wb_state_e          st_q;
  logic [LINE_W-1:0]  line_q;
  logic [DATA_W-1:0]  buf_q [WORDS];
  logic [WSEL_W-1:0]  beat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= WB_IDLE;
      beat_q <= '0;
    end else begin
      case (st_q)
        WB_IDLE: if (load) begin
          st_q   <= WB_ADDR;
          beat_q <= '0;
        end
        WB_ADDR: if (aw_ready) st_q <= WB_DATA;
        WB_DATA: if (w_ready) begin
          if (w_last) st_q <= WB_IDLE;
          beat_q <= beat_q + 1'b1;
        end
        default: st_q <= WB_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (load && st_q == WB_IDLE) begin
      line_q <= load_line;
      for (int i = 0; i < WORDS; i++) buf_q[i] <= load_data[i*DATA_W +: DATA_W];
    end
  end

  assign busy      = (st_q != WB_IDLE);
  assign line_addr = line_q;
  assign aw_valid  = (st_q == WB_ADDR);
  assign aw_addr   = {line_q, {OFF_W{1'b0}}};
  assign w_valid   = (st_q == WB_DATA);
  assign w_data    = buf_q[beat_q];
  assign w_last    = (beat_q == WSEL_W'(WORDS - 1));

  AST_LOAD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n) load |-> !busy); // R8
  AST_AW_HELD: assert property (@(posedge clk) disable iff (!rst_n) (aw_valid && !aw_ready) |=> (aw_valid && $stable(aw_addr))); // R11
  AST_BURST_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n) (w_valid && w_ready && !w_last) |=> w_valid); // R8
endmodule

// File: rtl/cc_policy_cache.sv
module cc_policy_cache
  import cc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int NUM_LINES  = 8,
  localparam int BE_W      = DATA_W / 8,
  localparam int WORDS     = LINE_BYTES / BE_W,
  localparam int LEN_W     = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  output logic              cpu_ready,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic [BE_W-1:0]   cpu_be,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_ar_valid,
  input  logic              mem_ar_ready,
  output logic [ADDR_W-1:0] mem_ar_addr,
  output logic [LEN_W-1:0]  mem_ar_len,
  input  logic              mem_r_valid,
  output logic              mem_r_ready,
  input  logic [DATA_W-1:0] mem_r_data,
  output logic              mem_aw_valid,
  input  logic              mem_aw_ready,
  output logic [ADDR_W-1:0] mem_aw_addr,
  output logic [LEN_W-1:0]  mem_aw_len,
  output logic              mem_w_valid,
  input  logic              mem_w_ready,
  output logic [DATA_W-1:0] mem_w_data,
  output logic [BE_W-1:0]   mem_w_strb,
  output logic              mem_w_last
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int BOFF_W = $clog2(BE_W);
  localparam int IDX_W  = $clog2(NUM_LINES);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int LINE_W = ADDR_W - OFF_W;

  ctl_state_e st_q, st_d;
  region_e    rgn;

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic [LEN_W-1:0]  word;
  logic [LINE_W-1:0] line;
  assign idx  = cpu_addr[OFF_W +: IDX_W];
  assign tag  = cpu_addr[ADDR_W-1 -: TAG_W];
  assign word = cpu_addr[BOFF_W +: LEN_W];
  assign line = cpu_addr[ADDR_W-1:OFF_W];

  cc_region_map u_map (.top_bits(cpu_addr[ADDR_W-1 -: 3]), .region(rgn));

  logic             ts_valid, ts_dirty, tag_wr_en, tag_wr_valid, tag_wr_dirty;
  logic [TAG_W-1:0] ts_tag;

  cc_tag_store #(.NUM_LINES(NUM_LINES), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .idx(idx),
    .rd_valid(ts_valid), .rd_dirty(ts_dirty), .rd_tag(ts_tag),
    .wr_en(tag_wr_en), .wr_valid(tag_wr_valid), .wr_dirty(tag_wr_dirty), .wr_tag(tag)
  );

  logic [DATA_W-1:0]       line_q [NUM_LINES][WORDS];
  logic [WORDS*DATA_W-1:0] victim_flat;
  for (genvar g = 0; g < WORDS; g++) begin : g_victim
    assign victim_flat[g*DATA_W +: DATA_W] = line_q[idx][g];
  end

  logic              wb_load, wb_busy, wb_aw_valid, wb_w_valid, wb_w_last;
  logic [LINE_W-1:0] wb_line;
  logic [ADDR_W-1:0] wb_aw_addr;
  logic [DATA_W-1:0] wb_w_data;

  cc_write_buffer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS)) u_wbuf (
    .clk(clk), .rst_n(rst_n), .load(wb_load),
    .load_line({ts_tag, idx}), .load_data(victim_flat),
    .busy(wb_busy), .line_addr(wb_line),
    .aw_valid(wb_aw_valid), .aw_ready(mem_aw_ready), .aw_addr(wb_aw_addr),
    .w_valid(wb_w_valid), .w_ready(mem_w_ready), .w_data(wb_w_data), .w_last(wb_w_last)
  );

  logic hit, fill_block, main_aw_valid, main_w_valid, main_aw_fire, main_w_fire;
  logic ar_fire, fill_beat, fill_last, store_upd;
  logic [LEN_W-1:0] fill_cnt;

  assign hit           = (rgn != RG_DEV) && ts_valid && (ts_tag == tag);
  assign fill_block    = wb_busy && (wb_line == line);
  assign main_aw_valid = (st_q == S_WR_REQ) && !wb_busy;
  assign main_w_valid  = (st_q == S_WR_DATA);
  assign main_aw_fire  = main_aw_valid && mem_aw_ready;
  assign main_w_fire   = main_w_valid && mem_w_ready;
  assign ar_fire       = mem_ar_valid && mem_ar_ready;
  assign fill_beat     = (st_q == S_FILL) && mem_r_valid;
  assign fill_last     = (fill_cnt == LEN_W'(WORDS - 1));
  assign store_upd     = ((st_q == S_LOOK) && cpu_valid && hit && cpu_we && rgn == RG_WB) ||
                         (main_w_fire && hit);
  assign wb_load       = (st_q == S_EVICT) && !wb_busy;

  // write channel: the buffer owns it whenever it holds a line
  assign mem_aw_valid = wb_busy ? wb_aw_valid : main_aw_valid;
  assign mem_aw_addr  = wb_busy ? wb_aw_addr : cpu_addr;
  assign mem_aw_len   = wb_busy ? LEN_W'(WORDS - 1) : '0;
  assign mem_w_valid  = wb_busy ? wb_w_valid : main_w_valid;
  assign mem_w_data   = wb_busy ? wb_w_data : cpu_wdata;
  assign mem_w_strb   = wb_busy ? {BE_W{1'b1}} : cpu_be;
  assign mem_w_last   = wb_busy ? wb_w_last : 1'b1;

  assign mem_ar_valid = ((st_q == S_FILL_REQ) && !fill_block) || (st_q == S_UNC_REQ);
  assign mem_ar_addr  = (st_q == S_UNC_REQ) ? {cpu_addr[ADDR_W-1:BOFF_W], {BOFF_W{1'b0}}}
                                            : {line, {OFF_W{1'b0}}};
  assign mem_ar_len   = (st_q == S_UNC_REQ) ? '0 : LEN_W'(WORDS - 1);
  assign mem_r_ready  = (st_q == S_FILL) || (st_q == S_UNC_DATA);
  assign cpu_rdata    = (st_q == S_UNC_DATA) ? mem_r_data : line_q[idx][word];

  always_comb begin
    case (st_q)
      S_LOOK:     cpu_ready = cpu_valid && hit && (!cpu_we || rgn == RG_WB);
      S_WR_DATA:  cpu_ready = main_w_fire;
      S_UNC_DATA: cpu_ready = mem_r_valid;
      default:    cpu_ready = 1'b0;
    endcase
  end

  always_comb begin
    tag_wr_en    = 1'b0;
    tag_wr_valid = 1'b0;
    tag_wr_dirty = 1'b0;
    if (wb_load) begin
      tag_wr_en = 1'b1;
    end else if (fill_beat && fill_last) begin
      tag_wr_en    = 1'b1;
      tag_wr_valid = 1'b1;
    end else if ((st_q == S_LOOK) && store_upd) begin
      tag_wr_en    = 1'b1;
      tag_wr_valid = 1'b1;
      tag_wr_dirty = 1'b1;
    end
  end

  always_comb begin
    st_d = st_q;
    case (st_q)
      S_LOOK: if (cpu_valid) begin
        if (rgn == RG_DEV)                      st_d = cpu_we ? S_WR_REQ : S_UNC_REQ;
        else if (cpu_we && rgn == RG_WT)        st_d = S_WR_REQ;
        else if (hit)                           st_d = S_LOOK;
        else if (ts_valid && ts_dirty)          st_d = S_EVICT;
        else                                    st_d = S_FILL_REQ;
      end
      S_EVICT:    if (!wb_busy) st_d = S_FILL_REQ;
      S_FILL_REQ: if (ar_fire) st_d = S_FILL;
      S_FILL:     if (fill_beat && fill_last) st_d = S_LOOK;
      S_WR_REQ:   if (main_aw_fire) st_d = S_WR_DATA;
      S_WR_DATA:  if (main_w_fire) st_d = S_LOOK;
      S_UNC_REQ:  if (ar_fire) st_d = S_UNC_DATA;
      S_UNC_DATA: if (mem_r_valid) st_d = S_LOOK;
      default:    st_d = S_LOOK;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= S_LOOK;
      fill_cnt <= '0;
    end else begin
      st_q <= st_d;
      if (fill_beat) fill_cnt <= fill_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_beat) begin
      line_q[idx][fill_cnt] <= mem_r_data;
    end else if (store_upd) begin
      for (int b = 0; b < BE_W; b++)
        if (cpu_be[b]) line_q[idx][word][b*8 +: 8] <= cpu_wdata[b*8 +: 8];
    end
  end

  AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n) cpu_ready |-> cpu_valid); // R11
  AST_DIRTY_ONLY_WB: assert property (@(posedge clk) disable iff (!rst_n) (tag_wr_en && tag_wr_dirty) |-> (rgn == RG_WB)); // R7
  AST_NO_DEV_ALLOC: assert property (@(posedge clk) disable iff (!rst_n) (tag_wr_en && tag_wr_valid) |-> (rgn != RG_DEV)); // R9
  AST_FILL_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n) (mem_ar_valid && mem_ar_len != '0) |-> !(wb_busy && wb_line == mem_ar_addr[ADDR_W-1:OFF_W])); // R10
  AST_AR_HELD: assert property (@(posedge clk) disable iff (!rst_n) (mem_ar_valid && !mem_ar_ready) |=> (mem_ar_valid && $stable(mem_ar_addr))); // R11
endmodule

// File: tb/tb_cc_policy_cache.sv
module tb_cc_policy_cache;
  localparam logic [31:0] KEY = 32'h5A5A_0000;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        cpu_valid = 1'b0, cpu_ready, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0, cpu_rdata;
  logic [3:0]  cpu_be = '0;
  logic        mem_ar_valid, mem_ar_ready, mem_r_valid, mem_r_ready;
  logic [31:0] mem_ar_addr, mem_aw_addr, mem_w_data;
  logic [2:0]  mem_ar_len, mem_aw_len;
  logic        mem_aw_valid, mem_aw_ready, mem_w_valid, mem_w_ready, mem_w_last;
  logic [3:0]  mem_w_strb;
  logic [31:0] r_data_q;

  cc_policy_cache dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_be(cpu_be), .cpu_rdata(cpu_rdata),
    .mem_ar_valid(mem_ar_valid), .mem_ar_ready(mem_ar_ready), .mem_ar_addr(mem_ar_addr),
    .mem_ar_len(mem_ar_len), .mem_r_valid(mem_r_valid), .mem_r_ready(mem_r_ready),
    .mem_r_data(r_data_q), .mem_aw_valid(mem_aw_valid), .mem_aw_ready(mem_aw_ready),
    .mem_aw_addr(mem_aw_addr), .mem_aw_len(mem_aw_len), .mem_w_valid(mem_w_valid),
    .mem_w_ready(mem_w_ready), .mem_w_data(mem_w_data), .mem_w_strb(mem_w_strb),
    .mem_w_last(mem_w_last)
  );

  int checks = 0, fails = 0;
  logic [31:0] mem_m [logic [31:0]];

  function automatic logic [31:0] mread(input logic [31:0] a);
    logic [31:0] w = {a[31:2], 2'b00};
    if (mem_m.exists(w)) return mem_m[w];
    return w ^ KEY;
  endfunction

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[31:2], 2'b00} ^ KEY;
  endfunction

  // memory model
  logic [31:0] rd_addr, wr_addr, last_ar_addr, last_aw_addr;
  logic [2:0]  last_ar_len, last_aw_len;
  int rd_left = 0, wr_left = 0, ar_cnt = 0, aw_cnt = 0, wbeat_cnt = 0, wlast_bad = 0, r11_bad = 0;
  logic [31:0] cyc = '0;
  logic slow_w = 1'b0, aw_hold = 1'b0;

  assign mem_ar_ready = (rd_left == 0);
  assign mem_r_valid  = (rd_left != 0);
  assign mem_aw_ready = (wr_left == 0);
  assign mem_w_ready  = (wr_left != 0) && (!slow_w || cyc[1:0] == 2'd3);

  always @(posedge clk) begin
    if (!rst_n) begin
      rd_left <= 0; wr_left <= 0; cyc <= '0;
    end else begin
      cyc <= cyc + 1;
      if (mem_ar_valid && mem_ar_ready) begin
        rd_addr <= {mem_ar_addr[31:2], 2'b00}; rd_left <= int'(mem_ar_len) + 1;
        r_data_q <= mread(mem_ar_addr); ar_cnt <= ar_cnt + 1;
        last_ar_addr <= mem_ar_addr; last_ar_len <= mem_ar_len;
      end else if (mem_r_valid && mem_r_ready) begin
        rd_addr <= rd_addr + 4; rd_left <= rd_left - 1; r_data_q <= mread(rd_addr + 4);
      end
      if (mem_aw_valid && mem_aw_ready) begin
        wr_addr <= {mem_aw_addr[31:2], 2'b00}; wr_left <= int'(mem_aw_len) + 1;
        aw_cnt <= aw_cnt + 1; last_aw_addr <= mem_aw_addr; last_aw_len <= mem_aw_len;
      end else if (mem_w_valid && mem_w_ready) begin
        logic [31:0] v;
        v = mread(wr_addr);
        for (int b = 0; b < 4; b++) if (mem_w_strb[b]) v[b*8 +: 8] = mem_w_data[b*8 +: 8];
        mem_m[wr_addr] = v;
        if (mem_w_last !== (wr_left == 1)) wlast_bad <= wlast_bad + 1;
        wbeat_cnt <= wbeat_cnt + 1; wr_addr <= wr_addr + 4; wr_left <= wr_left - 1;
      end
    end
  end

  // handshake monitor (R11)
  always @(negedge clk) begin
    if (rst_n) begin
      if (cpu_ready && !cpu_valid) r11_bad <= r11_bad + 1;
      if (aw_hold && !mem_aw_valid) r11_bad <= r11_bad + 1;
      aw_hold <= mem_aw_valid && !mem_aw_ready;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [31:0] a, input logic [31:0] d,
                        input logic [3:0] be, output logic [31:0] rd, output int waits);
    @(negedge clk);
    cpu_valid = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d; cpu_be = be; waits = 0;
    #1;
    while (!cpu_ready) begin
      @(negedge clk); #1; waits++;
    end
    rd = cpu_rdata;
    @(posedge clk); #1;
    cpu_valid = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] rd, merged;
    int w, a0, w0, b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1 ready idle", {31'b0, cpu_ready}, 32'd0);
    chk("R1 ar idle", {31'b0, mem_ar_valid}, 32'd0);
    chk("R1 aw/w idle", {30'b0, mem_aw_valid, mem_w_valid}, 32'd0);
    rst_n = 1'b1;

    // R4/R1: first cacheable load misses and refills
    a0 = ar_cnt;
    access(1'b0, 32'h0000_0104, '0, '0, rd, w);
    chk("R1 first access misses", {31'b0, w > 0}, 32'd1);
    chk("R4 miss data", rd, pat(32'h104));
    chk("R4 one burst", ar_cnt - a0, 32'd1);
    chk("R4 line aligned", last_ar_addr, 32'h0000_0100);
    chk("R4 len 7", {29'b0, last_ar_len}, 32'd7);

    // R3: hit
    a0 = ar_cnt;
    access(1'b0, 32'h0000_0108, '0, '0, rd, w);
    chk("R3 zero waits", w, 32'd0);
    chk("R3 hit data", rd, pat(32'h108));
    chk("R3 no read", ar_cnt - a0, 32'd0);

    // R5: write-through store hit
    a0 = ar_cnt; w0 = aw_cnt;
    merged = (pat(32'h108) & 32'hFFFF_0000) | 32'h0000_3344;
    access(1'b1, 32'h0000_0108, 32'h1122_3344, 4'b0011, rd, w);
    repeat (3) @(posedge clk);
    chk("R5 one write", aw_cnt - w0, 32'd1);
    chk("R5 single beat", {29'b0, last_aw_len}, 32'd0);
    chk("R5 address", last_aw_addr, 32'h0000_0108);
    chk("R5 memory merged", mread(32'h108), merged);
    access(1'b0, 32'h0000_0108, '0, '0, rd, w);
    chk("R5 cache merged", rd, merged);
    chk("R5 still hit", w, 32'd0);

    // R6: write-through store miss, no allocate
    a0 = ar_cnt; w0 = aw_cnt;
    access(1'b1, 32'h8000_0200, 32'hCAFE_F00D, 4'hF, rd, w);
    repeat (3) @(posedge clk);
    chk("R6 no refill", ar_cnt - a0, 32'd0);
    chk("R6 forwarded", aw_cnt - w0, 32'd1);
    a0 = ar_cnt; w0 = aw_cnt;
    access(1'b0, 32'h8000_0200, '0, '0, rd, w);
    chk("R6 later read misses", ar_cnt - a0, 32'd1);
    chk("R6 data", rd, 32'hCAFE_F00D);
    chk("R8 clean victim no write", aw_cnt - w0, 32'd0);

    // R7: write-back allocate and hit
    a0 = ar_cnt; w0 = aw_cnt;
    access(1'b1, 32'h2000_0040, 32'hDEAD_BEEF, 4'hF, rd, w);
    chk("R7 allocate refill", ar_cnt - a0, 32'd1);
    access(1'b1, 32'h2000_0044, 32'h0102_0304, 4'b1100, rd, w);
    chk("R7 hit store no wait", w, 32'd0);
    repeat (3) @(posedge clk);
    chk("R7 no external write", aw_cnt - w0, 32'd0);
    merged = (pat(32'h2000_0044) & 32'h0000_FFFF) | 32'h0102_0000;
    access(1'b0, 32'h2000_0044, '0, '0, rd, w);
    chk("R7 merged in cache", rd, merged);
    chk("R7 memory untouched", mread(32'h2000_0040), pat(32'h2000_0040));

    // R8: dirty eviction
    w0 = aw_cnt; b0 = wbeat_cnt;
    access(1'b0, 32'h6000_0040, '0, '0, rd, w);
    chk("R8 new line data", rd, pat(32'h6000_0040));
    repeat (30) @(posedge clk);
    chk("R8 one burst", aw_cnt - w0, 32'd1);
    chk("R8 victim address", last_aw_addr, 32'h2000_0040);
    chk("R8 len 7", {29'b0, last_aw_len}, 32'd7);
    chk("R8 eight beats", wbeat_cnt - b0, 32'd8);
    chk("R8 word0 written", mread(32'h2000_0040), 32'hDEAD_BEEF);
    chk("R8 word1 written", mread(32'h2000_0044), merged);

    // R10: read back a line still draining
    slow_w = 1'b1;
    access(1'b1, 32'h2000_0060, 32'h1357_9BDF, 4'hF, rd, w);
    access(1'b0, 32'h6000_0060, '0, '0, rd, w);
    access(1'b0, 32'h2000_0060, '0, '0, rd, w);
    chk("R10 drained data", rd, 32'h1357_9BDF);
    repeat (50) @(posedge clk);
    slow_w = 1'b0;

    // R9: device space
    for (int i = 0; i < 2; i++) begin
      a0 = ar_cnt;
      access(1'b0, 32'h4000_0010, '0, '0, rd, w);
      chk("R9 device read each time", ar_cnt - a0, 32'd1);
      chk("R9 device read len 0", {29'b0, last_ar_len}, 32'd0);
      chk("R9 device data", rd, pat(32'h4000_0010));
    end
    w0 = aw_cnt;
    access(1'b1, 32'hA000_0008, 32'h55AA_55AA, 4'hF, rd, w);
    repeat (3) @(posedge clk);
    chk("R9 device write", aw_cnt - w0, 32'd1);
    chk("R9 device write len 0", {29'b0, last_aw_len}, 32'd0);
    chk("R9 device memory", mread(32'hA000_0008), 32'h55AA_55AA);

    // R2: sweep all region codes
    for (int k = 0; k < 8; k++) begin
      logic [31:0] a;
      int cls;
      a = (32'(k) << 29) | 32'h0010_0000 | (32'(k) << 5);
      cls = (k == 0 || k == 4) ? 0 : (k == 1 || k == 3) ? 1 : 2;
      a0 = ar_cnt;
      access(1'b0, a, '0, '0, rd, w);
      chk("R2 first read burst", ar_cnt - a0, 32'd1);
      chk("R2 first read len", {29'b0, last_ar_len}, (cls == 2) ? 32'd0 : 32'd7);
      chk("R2 read data", rd, pat(a));
      a0 = ar_cnt;
      access(1'b0, a, '0, '0, rd, w);
      chk("R2 second read", ar_cnt - a0, (cls == 2) ? 32'd1 : 32'd0);
      w0 = aw_cnt;
      access(1'b1, a, 32'h0BAD_CAFE, 4'hF, rd, w);
      repeat (3) @(posedge clk);
      chk("R2 store traffic", aw_cnt - w0, (cls == 1) ? 32'd0 : 32'd1);
    end

    repeat (5) @(posedge clk);
    chk("R8 w_last placement", wlast_bad, 32'd0);
    chk("R11 handshake rules", r11_bad, 32'd0);
    finish_run();
  end
endmodule